// File: doc/BRIEF.md
# Inter-Pipeline Event Flag Synchronizer

This block sits between a single instruction front end and seven execution pipelines that run in parallel and share a local memory. The seven pipelines are scalar, vector, matrix, the copy from the level-1 buffer into the matrix operand buffers, the inbound copy from global memory, the outbound copy from the unified buffer to global memory, and the outbound copy from the matrix result buffer. Each pipeline offers one operation at a time on a ready/valid issue port. The operation is ordinary work, a set-flag, a wait-flag or a barrier. Set and wait operations name a peer pipeline and a 4-bit event number.

The block keeps one hardware flag bit for every ordered (producer, consumer, event) triple. It also keeps an outstanding-work counter per pipeline, which rises when ordinary work is issued and falls on a completion pulse. A set-flag is held until the issuing pipeline's earlier work has drained, and only then raises its bit. A wait-flag stalls its own pipeline until the bit is 1, then consumes the bit. A barrier stalls its pipeline until that pipeline has drained. Readiness is withheld per pipeline only, so a stalled pipeline never holds up the others.

Top module: `pipe_sync_hub`

## Requirements
- R1: A synchronous active-high reset clears every flag bit, every counter and the error output. After reset every `iss_ready` bit is 1, `ovf_err` is 0, and a wait issued right after reset stays blocked.
- R2: Pipeline numbers are 0 scalar, 1 vector, 2 matrix, 3 L1-to-operand copy, 4 global-inbound copy, 5 unified-buffer-outbound copy, 6 result-outbound copy. The op codes are 0 ordinary, 1 set-flag, 2 wait-flag, 3 barrier. A set on pipe p addresses flag (p, peer, event). A wait on pipe p addresses flag (peer, p, event).
- R3: An accepted ordinary op adds 1 to the pipe's outstanding count, and a completion pulse subtracts 1. A completion pulse at count 0 is ignored. `iss_ready` is low while the count equals 2^CNT_W-1, and it returns the cycle after a completion.
- R4: After a set-flag is accepted, `iss_ready` of that pipe is low. The flag bit is raised at the first clock edge where the registered count is 0, and ready returns in the same cycle. That edge comes one edge after acceptance when the count is already 0.
- R5: After a wait-flag is accepted, `iss_ready` of that pipe is low. At the first edge where the bit is 1, or is being set at that edge, the bit is cleared and ready returns. That edge comes no earlier than one edge after acceptance.
- R6: After a barrier is accepted, `iss_ready` stays low until the edge at which the registered count is 0. It touches no flag.
- R7: When a set and a consuming wait hit the same bit at the same edge, the waiter is released and the bit ends at 0, so a later wait on it blocks.
- R8: A set-flag that finds its bit already 1 raises the sticky `ovf_err` at that edge and leaves the bit at 1. Exactly one later wait is then released, and a second one blocks.
- R9: A set or wait whose peer value is 7 or higher (no such pipeline) behaves as a barrier and touches no flag.
- R10: A blocked pipeline leaves the `iss_ready` of every other pipeline unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | NP | Per-pipe issue request |
| iss_op | input | 2*NP | Per-pipe op code, pipe p at bits [2p+1:2p] |
| iss_peer | input | PW*NP | Per-pipe peer pipeline number |
| iss_evt | input | EW*NP | Per-pipe event number |
| done_pulse | input | NP | Per-pipe completion of one ordinary op |
| iss_ready | output | NP | Per-pipe issue acceptance |
| ovf_err | output | 1 | Sticky double-set error |

## Verification
A bit that is wrongly set or left behind shows at the ports as a waiting pipeline whose `iss_ready` returns one cycle after the wait is accepted, when it should stay low. A missing set shows as a waiter that never resumes. A counter that is off by one shows as a barrier or set-flag that releases a cycle early, before its last completion pulse, or that never releases. A broken saturation at zero shows as a pipeline that drops ready after a stray completion. Every such fault is visible within one or two cycles of the stimulus that exposes it. Because a consumed flag is observable only through a second wait, the bench follows each release with another wait on the same bit.

// File: rtl/pipe_sync_pkg.sv
package pipe_sync_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN   = 2'd0,
    OP_SET     = 2'd1,
    OP_WAIT    = 2'd2,
    OP_BARRIER = 2'd3
  } sync_op_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_WAIT  = 2'd2
  } issue_st_e;

  // Linear position of the flag for (producer, consumer, event).
  function automatic int flag_index(input int src, input int dst,
                                    input int evt, input int np,
                                    input int nev);
    return (src * np + dst) * nev + evt;
  endfunction

  // Outstanding-work update: a completion at zero is dropped.
  function automatic int count_next(input int cur, input logic inc,
                                    input logic dec);
    int r;
    r = cur;
    if (inc) r = r + 1;
    if (dec && cur != 0) r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/sync_issue_ctl.sv
module sync_issue_ctl
  import pipe_sync_pkg::*;
#(
  parameter int NP      = 7,
  parameter int PW      = 3,
  parameter int EW      = 4,
  parameter int CNT_W   = 4,
  parameter int FW      = 10,
  parameter int PIPE_ID = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [1:0]    op,
  input  logic [PW-1:0] peer,
  input  logic [EW-1:0] evt,
  input  logic          done,
  input  logic          wait_hit,
  output logic          ready,
  output logic          set_req,
  output logic [FW-1:0] set_idx,
  output logic          wait_act,
  output logic [FW-1:0] wait_idx,
  output logic          hold_drain,
  output logic          cnt_zero
);

  localparam int NEV = 1 << EW;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  issue_st_e      st_q;
  logic [PW-1:0]  peer_q;
  logic [EW-1:0]  evt_q;
  logic           set_pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic           fire;
  logic           peer_ok;
  sync_op_e       op_e;

  assign op_e     = sync_op_e'(op);
  assign peer_ok  = int'(peer) < NP;
  assign cnt_zero = (cnt_q == '0);
  assign ready    = (st_q == ST_RUN) && (cnt_q != CNT_MAX);
  assign fire     = valid && ready;

  assign cnt_d = CNT_W'(count_next(int'(cnt_q), fire && (op_e == OP_PLAIN), done));

  assign hold_drain = (st_q == ST_DRAIN);
  assign wait_act   = (st_q == ST_WAIT);
  assign set_req    = hold_drain && cnt_zero && set_pend_q;
  assign set_idx    = FW'(flag_index(PIPE_ID, int'(peer_q), int'(evt_q), NP, NEV));
  assign wait_idx   = FW'(flag_index(int'(peer_q), PIPE_ID, int'(evt_q), NP, NEV));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RUN;
      peer_q     <= '0;
      evt_q      <= '0;
      set_pend_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      cnt_q <= cnt_d;
      case (st_q)
        ST_RUN: begin
          if (fire) begin
            peer_q <= peer;
            evt_q  <= evt;
            case (op_e)
              OP_SET: begin
                st_q       <= ST_DRAIN;
                set_pend_q <= peer_ok;
              end
              OP_WAIT: begin
                st_q       <= peer_ok ? ST_WAIT : ST_DRAIN;
                set_pend_q <= 1'b0;
              end
              OP_BARRIER: begin
                st_q       <= ST_DRAIN;
                set_pend_q <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        ST_DRAIN: if (cnt_zero) st_q <= ST_RUN;
        ST_WAIT:  if (wait_hit) st_q <= ST_RUN;
        default:  st_q <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/sync_flag_bank.sv
module sync_flag_bank #(
  parameter int NP    = 7,
  parameter int FW    = 10,
  parameter int NFLAG = 784
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    set_req,
  input  logic [NP*FW-1:0] set_idx,
  input  logic [NP-1:0]    wait_act,
  input  logic [NP*FW-1:0] wait_idx,
  output logic [NP-1:0]    wait_hit,
  output logic             ovf_err
);

  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] flags_d;
  logic             ovf_q;
  logic             ovf_now;
  logic [NP-1:0]    clr;

  // A waiter sees its bit as stored or as being set this edge.
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      wait_hit[p] = flags_q[wait_idx[p*FW +: FW]];
      for (int q = 0; q < NP; q++) begin
        if (set_req[q] && set_idx[q*FW +: FW] == wait_idx[p*FW +: FW])
          wait_hit[p] = 1'b1;
      end
    end
    clr = wait_act & wait_hit;
  end

  // Sets land first, consuming clears second.
  always_comb begin
    flags_d = flags_q;
    ovf_now = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (set_req[p]) begin
        if (flags_q[set_idx[p*FW +: FW]]) ovf_now = 1'b1;
        flags_d[set_idx[p*FW +: FW]] = 1'b1;
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (clr[p]) flags_d[wait_idx[p*FW +: FW]] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      ovf_q   <= ovf_q | ovf_now;
    end
  end

  assign ovf_err = ovf_q;

endmodule

// File: rtl/pipe_sync_hub.sv
module pipe_sync_hub #(
  parameter int NP    = 7,
  parameter int PW    = 3,
  parameter int EW    = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    iss_valid,
  input  logic [2*NP-1:0]  iss_op,
  input  logic [PW*NP-1:0] iss_peer,
  input  logic [EW*NP-1:0] iss_evt,
  input  logic [NP-1:0]    done_pulse,
  output logic [NP-1:0]    iss_ready,
  output logic             ovf_err
);

  localparam int NEV   = 1 << EW;
  localparam int NFLAG = NP * NP * NEV;
  localparam int FW    = $clog2(NFLAG);

  logic [NP-1:0]    set_pulse;
  logic [NP*FW-1:0] set_idx;
  logic [NP-1:0]    hold_wait;
  logic [NP*FW-1:0] wait_idx;
  logic [NP-1:0]    wait_hit;
  logic [NP-1:0]    hold_drain;
  logic [NP-1:0]    cnt_zero;

  for (genvar p = 0; p < NP; p++) begin : g_pipe
    sync_issue_ctl #(
      .NP(NP), .PW(PW), .EW(EW), .CNT_W(CNT_W), .FW(FW), .PIPE_ID(p)
    ) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .valid     (iss_valid[p]),
      .op        (iss_op[2*p +: 2]),
      .peer      (iss_peer[PW*p +: PW]),
      .evt       (iss_evt[EW*p +: EW]),
      .done      (done_pulse[p]),
      .wait_hit  (wait_hit[p]),
      .ready     (iss_ready[p]),
      .set_req   (set_pulse[p]),
      .set_idx   (set_idx[FW*p +: FW]),
      .wait_act  (hold_wait[p]),
      .wait_idx  (wait_idx[FW*p +: FW]),
      .hold_drain(hold_drain[p]),
      .cnt_zero  (cnt_zero[p])
    );
  end

  sync_flag_bank #(.NP(NP), .FW(FW), .NFLAG(NFLAG)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_req (set_pulse),
    .set_idx (set_idx),
    .wait_act(hold_wait),
    .wait_idx(wait_idx),
    .wait_hit(wait_hit),
    .ovf_err (ovf_err)
  );

endmodule

// File: rtl/pipe_sync_hub_chk.sv
module pipe_sync_hub_chk #(
  parameter int NP = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] iss_ready,
  input logic [NP-1:0] hold_drain,
  input logic [NP-1:0] hold_wait,
  input logic [NP-1:0] cnt_zero,
  input logic [NP-1:0] set_pulse,
  input logic [NP-1:0] wait_hit,
  input logic [NP-1:0] done_pulse,
  input logic          ovf_err
);

  for (genvar p = 0; p < NP; p++) begin : g_chk
    a_r6_drain_blocks: assert property (@(posedge clk) disable iff (rst)
      hold_drain[p] |-> !iss_ready[p]);
    a_r5_wait_blocks: assert property (@(posedge clk) disable iff (rst)
      hold_wait[p] |-> !iss_ready[p]);
    a_r5_wait_release: assert property (@(posedge clk) disable iff (rst)
      $fell(hold_wait[p]) |-> $past(wait_hit[p]));
    a_r4_drain_release: assert property (@(posedge clk) disable iff (rst)
      $fell(hold_drain[p]) |-> $past(cnt_zero[p]));
    a_r3_zero_by_done: assert property (@(posedge clk) disable iff (rst)
      $rose(cnt_zero[p]) |-> $past(done_pulse[p]));
  end

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(|set_pulse));

endmodule

bind pipe_sync_hub pipe_sync_hub_chk #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_ready (iss_ready),
  .hold_drain(hold_drain),
  .hold_wait (hold_wait),
  .cnt_zero  (cnt_zero),
  .set_pulse (set_pulse),
  .wait_hit  (wait_hit),
  .done_pulse(done_pulse),
  .ovf_err   (ovf_err)
);

// File: tb/test_pipe_sync_hub.sv
`timescale 1ns/1ps
module test_pipe_sync_hub;

  localparam int NP = 7, PW = 3, EW = 4, CNT_W = 4;
  localparam int OPC_PLAIN = 0, OPC_SET = 1, OPC_WAIT = 2, OPC_BAR = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    iss_valid = '0;
  logic [2*NP-1:0]  iss_op = '0;
  logic [PW*NP-1:0] iss_peer = '0;
  logic [EW*NP-1:0] iss_evt = '0;
  logic [NP-1:0]    done_pulse = '0;
  logic [NP-1:0]    iss_ready;
  logic             ovf_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pipe_sync_hub #(.NP(NP), .PW(PW), .EW(EW), .CNT_W(CNT_W)) i_pipe_sync_hub (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_peer(iss_peer), .iss_evt(iss_evt), .done_pulse(done_pulse),
    .iss_ready(iss_ready), .ovf_err(ovf_err)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, after the accept edge.
  task automatic issue(input int p, input int o, input int peer, input int ev);
    iss_valid[p] = 1'b1;
    iss_op[2*p +: 2] = 2'(o);
    iss_peer[PW*p +: PW] = PW'(peer);
    iss_evt[EW*p +: EW] = EW'(ev);
    @(negedge clk);
    iss_valid[p] = 1'b0;
  endtask

  task automatic complete(input int p);
    done_pulse[p] = 1'b1;
    @(negedge clk);
    done_pulse[p] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", int'(iss_ready), 7'h7F);
    chk("R1", "ovf after reset", int'(ovf_err), 0);
  endtask

  // Wait blocks, same-edge set and consume, bit ends at zero.
  task automatic t_wait_and_collide;
    issue(1, OPC_WAIT, 4, 3);
    for (int i = 0; i < 4; i++) begin
      chk("R1", "wait on cleared flag blocks", int'(iss_ready[1]), 0);
      chk("R10", "other pipes ready", int'(iss_ready[0] & iss_ready[4]), 1);
      @(negedge clk);
    end
    issue(4, OPC_SET, 1, 3);
    chk("R4", "setter held one cycle", int'(iss_ready[4]), 0);
    @(negedge clk);
    chk("R4", "setter released", int'(iss_ready[4]), 1);
    chk("R7", "waiter released on same edge", int'(iss_ready[1]), 1);
    issue(1, OPC_WAIT, 4, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R7", "bit ended at zero", int'(iss_ready[1]), 0);
      @(negedge clk);
    end
    issue(4, OPC_SET, 1, 3);
    @(negedge clk);
    chk("R5", "second waiter released", int'(iss_ready[1]), 1);
    chk("R8", "no overflow on clean sets", int'(ovf_err), 0);
  endtask

  // Set deferred behind outstanding work, then consumed by wait.
  task automatic t_set_drain;
    for (int i = 0; i < 3; i++) issue(5, OPC_PLAIN, 0, 0);
    issue(5, OPC_SET, 2, 0);
    chk("R4", "set pending", int'(iss_ready[5]), 0);
    complete(5);
    complete(5);
    chk("R4", "set pending with one outstanding", int'(iss_ready[5]), 0);
    complete(5);
    chk("R4", "set resolves one edge after drain", int'(iss_ready[5]), 0);
    @(negedge clk);
    chk("R4", "set resolved", int'(iss_ready[5]), 1);
    issue(2, OPC_WAIT, 5, 0);
    chk("R5", "wait held at least one edge", int'(iss_ready[2]), 0);
    @(negedge clk);
    chk("R5", "wait found bit set", int'(iss_ready[2]), 1);
    issue(2, OPC_WAIT, 5, 1);
    @(negedge clk);
    chk("R2", "other event not set", int'(iss_ready[2]), 0);
    issue(5, OPC_SET, 2, 1);
    @(negedge clk);
    chk("R2", "event 1 released", int'(iss_ready[2]), 1);
  endtask

  task automatic t_barrier;
    issue(3, OPC_PLAIN, 0, 0);
    issue(3, OPC_PLAIN, 0, 0);
    issue(3, OPC_BAR, 0, 0);
    chk("R6", "barrier holds", int'(iss_ready[3]), 0);
    complete(3);
    chk("R6", "barrier holds one left", int'(iss_ready[3]), 0);
    complete(3);
    chk("R6", "barrier releases edge after drain", int'(iss_ready[3]), 0);
    @(negedge clk);
    chk("R6", "barrier released", int'(iss_ready[3]), 1);
    issue(6, OPC_WAIT, 3, 0);
    @(negedge clk);
    chk("R6", "barrier set no flag", int'(iss_ready[6]), 0);
    issue(3, OPC_SET, 6, 0);
    @(negedge clk);
    chk("R5", "wait released by set", int'(iss_ready[6]), 1);
  endtask

  task automatic t_count_limits;
    for (int i = 0; i < 15; i++) issue(2, OPC_PLAIN, 0, 0);
    chk("R3", "full counter blocks", int'(iss_ready[2]), 0);
    complete(2);
    chk("R3", "completion reopens", int'(iss_ready[2]), 1);
    for (int i = 0; i < 14; i++) complete(2);
    complete(2);
    chk("R3", "extra completion ignored", int'(iss_ready[2]), 1);
    issue(2, OPC_PLAIN, 0, 0);
    issue(2, OPC_BAR, 0, 0);
    @(negedge clk);
    chk("R3", "count held at one", int'(iss_ready[2]), 0);
    complete(2);
    chk("R3", "barrier still pending", int'(iss_ready[2]), 0);
    @(negedge clk);
    chk("R3", "barrier released after drain", int'(iss_ready[2]), 1);
  endtask

  task automatic t_bad_peer;
    issue(1, OPC_PLAIN, 0, 0);
    issue(1, OPC_SET, 7, 0);
    @(negedge clk);
    chk("R9", "invalid set waits drain", int'(iss_ready[1]), 0);
    complete(1);
    @(negedge clk);
    chk("R9", "invalid set released", int'(iss_ready[1]), 1);
    issue(1, OPC_WAIT, 7, 0);
    chk("R9", "invalid wait held", int'(iss_ready[1]), 0);
    @(negedge clk);
    chk("R9", "invalid wait acts as barrier", int'(iss_ready[1]), 1);
  endtask

  task automatic t_overflow;
    issue(0, OPC_SET, 6, 7);
    @(negedge clk);
    chk("R8", "first set clean", int'(ovf_err), 0);
    issue(0, OPC_SET, 6, 7);
    @(negedge clk);
    chk("R8", "double set flags error", int'(ovf_err), 1);
    issue(6, OPC_WAIT, 0, 7);
    @(negedge clk);
    chk("R8", "bit stayed one", int'(iss_ready[6]), 1);
    issue(6, OPC_WAIT, 0, 7);
    @(negedge clk);
    @(negedge clk);
    chk("R8", "only one wait released", int'(iss_ready[6]), 0);
    issue(0, OPC_SET, 6, 7);
    @(negedge clk);
    chk("R8", "waiter released", int'(iss_ready[6]), 1);
    chk("R8", "error sticky", int'(ovf_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wait_and_collide();
    t_set_drain();
    t_barrier();
    t_count_limits();
    t_bad_peer();
    t_overflow();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule